// File: doc/BRIEF.md
# Byte-Addressed Instruction Fetch Unit

This block is the front end of a simple in-order processor core. It keeps the program counter and a small read-only program store that is organised as individual bytes. Every cycle it presents the current PC, the address of the following instruction (PC + 4, which jump instructions write as their link value), and the 32-bit instruction found at the PC. The word is formed by joining four consecutive bytes, with the byte at the lowest address in the most significant position.

Each rising clock edge loads a new PC. The new value is chosen from three sources. The first is the sequential address. The second is a PC-relative target for branches and direct jumps. The third is an absolute target computed by the ALU for register-indirect jumps. The instruction read is combinational from the PC, so a new instruction appears in the same cycle as the PC that addresses it. The program store is filled at elaboration from a formula, so no external image file is needed.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. Reset wins over every other select input.
- R2: With `rst`, `take_branch` and `reg_jump` all low, each rising edge advances the PC by 4.
- R3: With `take_branch` high and `reg_jump` low, the next PC is PC + `imm_ofs`. The addition is in two's complement modulo 2^32, so a negative offset moves the PC backward.
- R4: With `reg_jump` high, the next PC is `jump_target`, whatever the value of `take_branch`.
- R5: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32, in the same cycle.
- R6: `instr_o` is built from the four bytes at word-aligned byte addresses A..A+3. The byte at offset 0 drives bits 31:24, offset 1 drives bits 23:16, offset 2 drives bits 15:8 and offset 3 drives bits 7:0. For word index k (k = A/4, modulo 256), the bytes at offsets 0..3 hold k, k XOR 0xA5, (k + 0x3C) mod 256, and NOT k.
- R7: PC bits 1:0 are ignored for the fetch. A PC of 4k+1, 4k+2 or 4k+3 fetches word k, while `pc_o` and `pc_plus4_o` keep the unaligned value.
- R8: PC bits 31:10 are ignored for the fetch. The 1024-byte store wraps, so PC 0x400 fetches word 0.
- R9: The PC changes only at a rising clock edge. `instr_o` follows the PC in the same cycle, with no additional register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| take_branch | input | 1 | Selects PC + `imm_ofs` as the next PC |
| imm_ofs | input | 32 | Sign-extended PC-relative offset |
| reg_jump | input | 1 | Selects `jump_target` as the next PC; has priority over `take_branch` |
| jump_target | input | 32 | ALU-computed absolute target for register jumps |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC + 4 (link value) |
| instr_o | output | 32 | Instruction word fetched at the current PC |

## Verification
The select inputs and the reset act through exactly one register, the PC. Their effect on `pc_o`, on `pc_plus4_o` and on `instr_o` is therefore due one cycle after they are presented. `pc_plus4_o` and `instr_o` then follow the new PC in that same cycle, with no extra delay. The bench changes its inputs on the falling edge and waits one rising edge. It samples all three outputs a short time after that edge, which is after the PC register has loaded and the combinational read has settled, and before the next falling edge changes the inputs again. The expected instruction words come from the content formula in R6, computed separately inside the bench.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  // Source chosen for the next program counter value
  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_REL = 2'd1,
    NPC_REG = 2'd2
  } npc_src_e;

  // Initial content of the byte-organised program store.
  // Word k holds bytes {k, k^A5, k+3C, ~k}, with the first byte at the lowest address.
  function automatic logic [7:0] rom_byte(input int unsigned byte_addr);
    logic [7:0] k;
    k = 8'(byte_addr >> 2);
    case (byte_addr & 3)
      0:       rom_byte = k;
      1:       rom_byte = k ^ 8'hA5;
      2:       rom_byte = k + 8'h3C;
      default: rom_byte = ~k;
    endcase
  endfunction

endpackage

// File: rtl/ifetch_next_pc.sv
module ifetch_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_cur,
  input  logic            take_branch,
  input  logic [XLEN-1:0] imm_ofs,
  input  logic            reg_jump,
  input  logic [XLEN-1:0] jump_target,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_seq
);
  import ifetch_pkg::*;

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  npc_src_e src;

  // The register jump outranks the relative path
  always_comb begin
    if (reg_jump)         src = NPC_REG;
    else if (take_branch) src = NPC_REL;
    else                  src = NPC_SEQ;
  end

  assign pc_seq = pc_cur + INSN_BYTES;

  always_comb begin
    case (src)
      NPC_REG: pc_next = jump_target;
      NPC_REL: pc_next = pc_cur + imm_ofs;
      default: pc_next = pc_seq;
    endcase
  end

endmodule

// File: rtl/ifetch_pc_reg.sv
module ifetch_pc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_next,
  input  logic            take_branch,
  input  logic [XLEN-1:0] imm_ofs,
  input  logic            reg_jump,
  input  logic [XLEN-1:0] jump_target,
  output logic [XLEN-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc_q == '0);

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_jump && !take_branch) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R3
  pc_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_jump && take_branch) |=> pc_q == $past(pc_q) + $past(imm_ofs));

  // R4
  pc_regjump_chk: assert property (@(posedge clk) disable iff (rst)
    reg_jump |=> pc_q == $past(jump_target));

endmodule

// File: rtl/ifetch_byte_rom.sv
module ifetch_byte_rom #(
  parameter int ADDR_W = 10,
  parameter int XLEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-3:0] word_addr,
  output logic [XLEN-1:0]   instr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = XLEN / 8;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = ifetch_pkg::rom_byte(a);
  end

  // The lowest byte address is placed in the most significant lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign instr[XLEN-1-8*g -: 8] = mem[{word_addr, 2'(g)}];
  end

  // R6
  rom_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(word_addr) |-> $stable(instr));

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_branch,
  input  logic [XLEN-1:0] imm_ofs,
  input  logic            reg_jump,
  input  logic [XLEN-1:0] jump_target,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_plus4_o,
  output logic [XLEN-1:0] instr_o
);

  logic [XLEN-1:0] pc_q, pc_next, pc_seq;

  ifetch_next_pc #(.XLEN(XLEN)) u_npc (
    .pc_cur(pc_q), .take_branch(take_branch), .imm_ofs(imm_ofs),
    .reg_jump(reg_jump), .jump_target(jump_target),
    .pc_next(pc_next), .pc_seq(pc_seq)
  );

  ifetch_pc_reg #(.XLEN(XLEN)) u_pc (
    .clk(clk), .rst(rst), .pc_next(pc_next), .take_branch(take_branch),
    .imm_ofs(imm_ofs), .reg_jump(reg_jump), .jump_target(jump_target),
    .pc_q(pc_q)
  );

  // R7, R8: only the word-index bits of the PC address the store
  ifetch_byte_rom #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_rom (
    .clk(clk), .rst(rst), .word_addr(pc_q[ADDR_W-1:2]), .instr(instr_o)
  );

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_seq;

  // R5
  link_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pc_plus4_o - pc_o == XLEN'(4));

endmodule

// File: tb/sim_ifetch_unit.sv
`timescale 1ns/1ps
module sim_ifetch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_branch = 1'b0;
  logic [31:0] imm_ofs = '0;
  logic        reg_jump = 1'b0;
  logic [31:0] jump_target = '0;
  logic [31:0] pc_o, pc_plus4_o, instr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ifetch_unit u0 (
    .clk(clk), .rst(rst), .take_branch(take_branch), .imm_ofs(imm_ofs),
    .reg_jump(reg_jump), .jump_target(jump_target),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o), .instr_o(instr_o)
  );

  // Expected word from the R6 content formula
  function automatic logic [31:0] exp_word(input logic [31:0] pc);
    logic [7:0] k;
    k = pc[9:2];
    return {k, k ^ 8'hA5, 8'(k + 8'h3C), ~k};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled 1 ns after the next rising edge
  task automatic step(input logic r, input logic br, input logic [31:0] imm,
                      input logic rj, input logic [31:0] tgt);
    @(negedge clk);
    rst = r; take_branch = br; imm_ofs = imm; reg_jump = rj; jump_target = tgt;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_pc(input string tag, input logic [31:0] pc);
    check({tag, " pc"}, pc_o, pc);
    check("R5 link", pc_plus4_o, pc + 32'd4);
    check({tag, " instr"}, instr_o, exp_word(pc));
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 32'h10, 1'b0, 32'h0);
    step(1'b1, 1'b0, 32'h0, 1'b0, 32'h0);
    expect_pc("R1", 32'h0);
    check("R6 word0", instr_o, 32'h00A53CFF);
  endtask

  task automatic t_sequential;
    for (int i = 1; i <= 3; i++) begin
      step(1'b0, 1'b0, 32'hDEAD, 1'b0, 32'h0);
      expect_pc("R2", 32'(4 * i));
    end
  endtask

  task automatic t_relative;
    step(1'b0, 1'b1, 32'h40, 1'b0, 32'h0);
    expect_pc("R3 fwd", 32'h4C);
    check("R9 fwd instr", instr_o, {8'h13, 8'h13 ^ 8'hA5, 8'h4F, 8'hEC});
    step(1'b0, 1'b1, 32'hFFFF_FFF8, 1'b0, 32'h0);
    expect_pc("R3 back", 32'h44);
  endtask

  task automatic t_reg_jump;
    step(1'b0, 1'b1, 32'h8, 1'b1, 32'h200);
    expect_pc("R4 prio", 32'h200);
    step(1'b0, 1'b0, 32'h0, 1'b1, 32'h2F0);
    expect_pc("R4 plain", 32'h2F0);
  endtask

  task automatic t_unaligned;
    step(1'b0, 1'b0, 32'h0, 1'b1, 32'h106);
    check("R7 pc", pc_o, 32'h106);
    check("R7 link", pc_plus4_o, 32'h10A);
    check("R7 instr", instr_o, exp_word(32'h104));
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R7 seq pc", pc_o, 32'h10A);
    check("R7 seq instr", instr_o, exp_word(32'h108));
  endtask

  task automatic t_wrap;
    step(1'b0, 1'b0, 32'h0, 1'b1, 32'h3FC);
    expect_pc("R8 top", 32'h3FC);
    check("R8 top word", instr_o, {8'hFF, 8'h5A, 8'h3B, 8'h00});
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R8 wrap pc", pc_o, 32'h400);
    check("R8 wrap instr", instr_o, 32'h00A53CFF);
    step(1'b0, 1'b0, 32'h0, 1'b1, 32'h8000_0010);
    check("R8 high instr", instr_o, exp_word(32'h10));
  endtask

  task automatic t_reset_prio;
    step(1'b1, 1'b1, 32'h44, 1'b1, 32'h300);
    expect_pc("R1 prio", 32'h0);
    step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    expect_pc("R2 after reset", 32'h4);
  endtask

  initial begin
    t_reset;
    t_sequential;
    t_relative;
    t_reg_jump;
    t_unaligned;
    t_wrap;
    t_reset_prio;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule